// File: doc/BRIEF.md
# Programmable-Frame Asynchronous Serial Transmitter

This block turns bytes written into an internal transmit queue into asynchronous serial frames on one output line. The frame shape is set at run time: five to eight data bits, an optional parity bit of either sense, and one or two stop bits. A separate control forces the line to the spacing level to signal a break. Bit timing comes from an oversampling enable tick that the surrounding logic produces. Each bit lasts a fixed number of those ticks.

The host side pushes bytes into the queue and can flush it. Two status flags come back. One shows that the queue is empty. The other shows that the queue and the shifter are both empty, so the line has gone quiet. The frame settings are captured when a byte leaves the queue. Changing them while a frame is on the line therefore has no effect until the next frame.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever the transmitter is fully idle with break off, `txd_o` is high, and `fifo_empty_o` and `tx_idle_o` are 1.
- R2: A frame starts with one low start bit, followed by the data bits least significant first. The data length is set by `wlen_i`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above that length are not sent.
- R3: When `par_en_i` is 1, a parity bit follows the data. With `par_even_i` = 1 the XOR of the sent data bits and the parity bit is 0. With `par_even_i` = 0 that XOR is 1.
- R4: Stop bits are high. `two_stop_i` = 0 sends one stop bit and `two_stop_i` = 1 sends two.
- R5: Each bit lasts OVS rising edges of `baud_tick_i` (default 16).
- R6: While `brk_i` is 1, `txd_o` is low from the next clock onward, whether or not a frame is in progress.
- R7: The queue holds DEPTH bytes and sends them in push order. `fifo_full_o` is 1 when it holds DEPTH bytes. A push while full is ignored and produces no frame.
- R8: A pulse on `fifo_clr_i` empties the queue by the next clock, so the discarded bytes are never sent. A frame already being shifted completes.
- R9: `fifo_empty_o` is 1 exactly when the queue holds no bytes. It goes 1 as soon as the last byte moves into the shifter, even though that byte is still being sent.
- R10: `tx_idle_o` is 1 only when the queue is empty and no frame is in progress. It rises once the last stop bit has finished.
- R11: The next byte is taken from the queue only after the final stop bit of the current frame. The frame settings used for a frame are those present when its byte was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | Oversampling enable, OVS per bit |
| push_i | input | 1 | Write one byte into the queue |
| push_data_i | input | 8 | Byte to write |
| fifo_clr_i | input | 1 | Flush the queue |
| wlen_i | input | 2 | Data length code (0..3 gives 5..8 bits) |
| par_en_i | input | 1 | Add a parity bit |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| two_stop_i | input | 1 | 1 selects two stop bits |
| brk_i | input | 1 | Force the line low |
| txd_o | output | 1 | Serial output, idles high |
| fifo_empty_o | output | 1 | Queue holds no bytes |
| fifo_full_o | output | 1 | Queue holds DEPTH bytes |
| tx_idle_o | output | 1 | Queue and shifter both empty |

## Verification
The bench builds the block with DEPTH = 4 and OVS = 4, and applies one tick every three clocks, so one bit spans twelve clocks. The small queue makes the full flag, the push refused while full, and a flush of several waiting bytes reachable within a few frames. The short bit period allows every length, parity and stop combination, back-to-back frames, and a settings change in mid-frame to be decoded at mid-bit in a short run.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;      // 0..3 -> 5..8 data bits
    logic       par_en;
    logic       par_even;
    logic       two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              empty_o,
  output logic              full_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign do_push    = push_i && !full_o && !clr_i;
  assign do_pop     = pop_i && !empty_o && !clr_i;
  assign pop_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic bit_done_o
);

  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [CW-1:0] cnt_q;

  assign bit_done_o = tick_i && (cnt_q == CW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (bit_done_o) cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  frame_cfg_t        cfg_i,
  input  logic              bit_done_i,
  output logic              pop_o,
  output logic              line_o,
  output logic              busy_o
);

  tx_state_e         state_q;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] sr_q;
  logic [2:0]        idx_q;
  logic              par_q;
  logic              stop2_q;
  logic [2:0]        last_idx;

  assign last_idx = 3'd4 + {1'b0, cfg_q.wlen};
  assign pop_o    = (state_q == ST_IDLE) && !fifo_empty_i;
  assign busy_o   = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sr_q[0];
      ST_PAR:   line_o = cfg_q.par_even ? par_q : ~par_q;
      default:  line_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      sr_q    <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (pop_o) begin
          sr_q    <= fifo_data_i;
          cfg_q   <= cfg_i;       // settings frozen per frame
          par_q   <= 1'b0;
          state_q <= ST_START;
        end
        ST_START: if (bit_done_i) begin
          idx_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (bit_done_i) begin
          par_q <= par_q ^ sr_q[0];
          sr_q  <= sr_q >> 1;
          if (idx_q == last_idx) begin
            stop2_q <= 1'b0;
            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_PAR: if (bit_done_i) begin
          stop2_q <= 1'b0;
          state_q <= ST_STOP;
        end
        ST_STOP: if (bit_done_i) begin
          if (cfg_q.two_stop && !stop2_q) stop2_q <= 1'b1;
          else                            state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OVS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       push_i,
  input  logic [7:0] push_data_i,
  input  logic       fifo_clr_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       two_stop_i,
  input  logic       brk_i,
  output logic       txd_o,
  output logic       fifo_empty_o,
  output logic       fifo_full_o,
  output logic       tx_idle_o
);

  localparam int DATA_W = 8;

  logic [DATA_W-1:0] fifo_data;
  logic              pop, bit_done, line, busy;
  frame_cfg_t        cfg;
  logic              txd_q;

  assign cfg = '{wlen: wlen_i, par_en: par_en_i, par_even: par_even_i, two_stop: two_stop_i};

  uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (fifo_clr_i),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop),
    .pop_data_o  (fifo_data),
    .empty_o     (fifo_empty_o),
    .full_o      (fifo_full_o)
  );

  uart_tx_bit_timer #(.OVS(OVS)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (pop),
    .tick_i     (baud_tick_i),
    .bit_done_o (bit_done)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty_o),
    .fifo_data_i  (fifo_data),
    .cfg_i        (cfg),
    .bit_done_i   (bit_done),
    .pop_o        (pop),
    .line_o       (line),
    .busy_o       (busy)
  );

  // registered output, break overrides frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) txd_q <= 1'b1;
    else         txd_q <= brk_i ? 1'b0 : line;
  end

  assign txd_o     = txd_q;
  assign tx_idle_o = fifo_empty_o && !busy;

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic push_i,
  input logic fifo_clr_i,
  input logic brk_i,
  input logic txd_o,
  input logic fifo_empty_o,
  input logic tx_idle_o
);

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_idle_o && !brk_i) |=> txd_o);

  assert_break_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !txd_o);

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> fifo_empty_o);

  assert_push_fills_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !fifo_clr_i) |=> !fifo_empty_o);

  assert_idle_after_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_idle_o) && !$past(brk_i)) |-> txd_o);

endmodule

bind uart_tx_core uart_tx_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .fifo_clr_i   (fifo_clr_i),
  .brk_i        (brk_i),
  .txd_o        (txd_o),
  .fifo_empty_o (fifo_empty_o),
  .tx_idle_o    (tx_idle_o)
);

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;

  localparam int DEPTH = 4;
  localparam int OVS   = 4;
  localparam int TP    = 3;          // clocks per tick
  localparam int BIT   = OVS * TP;   // clocks per bit
  localparam int HALF  = BIT / 2;

  typedef struct {
    logic [7:0] d;
    logic [1:0] wl;
    logic       pen;
    logic       peven;
    logic       two;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       push_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic       fifo_clr_i = 1'b0;
  logic [1:0] wlen_i = 2'd3;
  logic       par_en_i = 1'b0;
  logic       par_even_i = 1'b0;
  logic       two_stop_i = 1'b0;
  logic       brk_i = 1'b0;
  logic       txd_o, fifo_empty_o, fifo_full_o, tx_idle_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  uart_tx_core #(.DEPTH(DEPTH), .OVS(OVS)) i_uart_tx_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .baud_tick_i  (baud_tick_i),
    .push_i       (push_i),
    .push_data_i  (push_data_i),
    .fifo_clr_i   (fifo_clr_i),
    .wlen_i       (wlen_i),
    .par_en_i     (par_en_i),
    .par_even_i   (par_even_i),
    .two_stop_i   (two_stop_i),
    .brk_i        (brk_i),
    .txd_o        (txd_o),
    .fifo_empty_o (fifo_empty_o),
    .fifo_full_o  (fifo_full_o),
    .tx_idle_o    (tx_idle_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // tick generator
  initial begin
    int c = 0;
    forever begin
      @(negedge clk_i);
      baud_tick_i = (c == TP - 1);
      c = (c == TP - 1) ? 0 : c + 1;
    end
  end

  task automatic set_cfg(input logic [1:0] wl, input logic pen, input logic ev, input logic two);
    wlen_i = wl; par_en_i = pen; par_even_i = ev; two_stop_i = two;
  endtask

  // driver: push and record expected frame unless refused
  task automatic push_byte(input logic [7:0] d);
    exp_t e;
    @(negedge clk_i);
    e.d = d; e.wl = wlen_i; e.pen = par_en_i; e.peven = par_even_i; e.two = two_stop_i;
    if (!fifo_full_o) q.push_back(e);
    push_i = 1'b1; push_data_i = d;
    @(negedge clk_i);
    push_i = 1'b0;
  endtask

  task automatic push_raw(input logic [7:0] d);
    @(negedge clk_i);
    push_i = 1'b1; push_data_i = d;
    @(negedge clk_i);
    push_i = 1'b0;
  endtask

  task automatic drain();
    while (!(q.size() == 0 && tx_idle_o === 1'b1)) @(negedge clk_i);
    repeat (2 * BIT) @(negedge clk_i);
  endtask

  // monitor: decode frames at mid-bit, compare against queue front
  initial begin
    exp_t e;
    int nb;
    logic [7:0] got, md;
    forever begin
      @(negedge clk_i);
      if (rst_ni && !brk_i && txd_o === 1'b0) begin
        if (q.size() == 0) begin
          chk("R7/R8 unexpected frame", 1, 0);
          wait (txd_o === 1'b1);
        end else begin
          e = q.pop_front();
          nb = 5 + int'(e.wl);
          md = e.d & 8'((1 << nb) - 1);
          repeat (HALF) @(negedge clk_i);
          chk("R2 start bit", int'(txd_o), 0);
          got = '0;
          for (int i = 0; i < nb; i++) begin
            repeat (BIT) @(negedge clk_i);
            got[i] = txd_o;
          end
          chk("R2/R7/R11 data", int'(got), int'(md));
          if (e.pen) begin
            repeat (BIT) @(negedge clk_i);
            chk("R3 parity bit", int'(txd_o), int'(e.peven ? ^md : ~^md));
          end
          repeat (BIT) @(negedge clk_i);
          chk("R4 stop bit 1", int'(txd_o), 1);
          if (e.two) begin
            repeat (BIT) @(negedge clk_i);
            chk("R4 stop bit 2", int'(txd_o), 1);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    chk("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int len;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset txd", int'(txd_o), 1);
    chk("R1 reset empty", int'(fifo_empty_o), 1);
    chk("R1 reset idle", int'(tx_idle_o), 1);
    chk("R7 reset full", int'(fifo_full_o), 0);

    // single 8N1 frame; flags while in flight
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    push_byte(8'hA5);
    @(negedge clk_i);
    chk("R9 empty after fetch", int'(fifo_empty_o), 1);
    chk("R10 not idle in frame", int'(tx_idle_o), 0);
    drain();
    chk("R10 idle after frame", int'(tx_idle_o), 1);

    // length, parity and stop combinations
    set_cfg(2'd0, 1'b1, 1'b1, 1'b1); push_byte(8'hFF); drain();
    set_cfg(2'd1, 1'b1, 1'b0, 1'b0); push_byte(8'h2C); drain();
    set_cfg(2'd2, 1'b1, 1'b1, 1'b0); push_byte(8'h55); drain();
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1); push_byte(8'h00); drain();
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
    push_byte(8'h12); push_byte(8'h34); push_byte(8'hC7); drain();

    // start bit duration (R5)
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    push_byte(8'h01);
    while (txd_o === 1'b1) @(negedge clk_i);
    len = 0;
    while (txd_o === 1'b0) begin @(negedge clk_i); len++; end
    chk("R5 bit length in window", int'(len >= BIT - TP && len <= BIT + TP), 1);
    drain();

    // break (R6)
    brk_i = 1'b1;
    @(negedge clk_i);
    chk("R6 break low", int'(txd_o), 0);
    repeat (30) @(negedge clk_i);
    chk("R6 break held", int'(txd_o), 0);
    brk_i = 1'b0;
    @(negedge clk_i);
    chk("R1 release high", int'(txd_o), 1);

    // full and refused push (R7)
    push_byte(8'h81);
    repeat (3) @(negedge clk_i);
    push_byte(8'h82); push_byte(8'h83); push_byte(8'h84); push_byte(8'h85);
    chk("R7 full flag", int'(fifo_full_o), 1);
    push_byte(8'h99);
    drain();

    // flush while a frame is in flight (R8)
    push_byte(8'h11);
    repeat (3) @(negedge clk_i);
    push_raw(8'hE1); push_raw(8'hE2); push_raw(8'hE3);
    chk("R9 queued not empty", int'(fifo_empty_o), 0);
    @(negedge clk_i);
    fifo_clr_i = 1'b1;
    @(negedge clk_i);
    fifo_clr_i = 1'b0;
    chk("R8 empty after clear", int'(fifo_empty_o), 1);
    chk("R8 frame continues", int'(tx_idle_o), 0);
    drain();
    repeat (4 * 12 * BIT) @(negedge clk_i);
    chk("R8 no flushed frame", int'(tx_idle_o), 1);

    // settings change mid-frame (R11)
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    push_byte(8'h3C);
    while (txd_o === 1'b1) @(negedge clk_i);
    repeat (BIT) @(negedge clk_i);
    set_cfg(2'd0, 1'b1, 1'b1, 1'b1);
    drain();
    chk("R11 queue consumed", q.size(), 0);

    finish_run();
  end

endmodule